// File: doc/BRIEF.md
# Byte-Wise Serial DAC Frame Master

This block is the host side of a three-wire link to a 16-bit voltage-output converter. Each command on a valid/ready port carries a two-bit operating-mode field and a 16-bit code. The block turns the command into a 24-bit frame: six zero pad bits, then the mode field, then the code. It sends the frame as three 8-bit transfers, and the active-low frame strobe stays asserted across all three. The receiver samples data on the falling edge of an idle-low serial clock. The block therefore changes data on the rising edge and holds it stable through the falling edge.

The byte engine can shift either most- or least-significant bit first, chosen per frame by a configuration input. In least-first mode each byte is bit-reversed before it is loaded, so the wire order is always most-significant bit first across the whole frame. The serial clock comes from the system clock. Its half period in system cycles is derived at elaboration from the clock period and the rate limit for each supply range. A second configuration input picks the slower limit for low supply voltages. Between frames the strobe stays high for at least 33 ns, rounded up to whole system cycles. An optional pause of a set number of system cycles, with the clock low and the strobe held low, can be placed between bytes. A one-cycle done pulse marks the end of each frame.

Top module: `dac_frame_master`

## Requirements
- R1: `sync_n` goes low when a command is accepted, stays low through all three byte transfers, and returns high one serial-clock half period after the 24th falling `sclk` edge. No falling `sclk` edge occurs while `sync_n` is high.
- R2: Each frame produces exactly 24 falling `sclk` edges, in three groups of eight. Within a group, falling edges are 2·H system cycles apart. Between the 8th and 9th edges, and between the 16th and 17th edges, the gap is 2·H + BYTE_IDLE cycles.
- R3: With `cfg_lsb_first`=0, the 24 bits sampled on the falling edges, first bit as bit 23, equal {6'b000000, `cmd_mode`[1:0], `cmd_code`[15:0]}. Bits 23..18 are zero, bits 17..16 are the mode and bits 15..0 are the code.
- R4: With `cfg_lsb_first`=1, the byte engine shifts least-significant bit first on bit-reversed bytes, and the sampled word is identical to the one in R3.
- R5: `sclk` is low whenever `sync_n` is high. `din` changes only in the cycle in which `sclk` rises, so it is stable at every falling edge.
- R6: H, the `sclk` high time and low time in system cycles, is ceil(ceil(Pmin/2)/Tclk), where Pmin is 33334 ps when `cfg_low_supply`=0 and 50000 ps when it is 1. With Tclk=4000 ps this gives H=5 and H=7, and the clock never exceeds 30 MHz or 20 MHz respectively.
- R7: Between consecutive frames, `sync_n` stays high for at least ceil(33000 ps / Tclk) system cycles (9 at 4 ns).
- R8: `cmd_ready` is high only while the block is idle. A command is taken only on `cmd_valid` && `cmd_ready`. A `cmd_valid` pulse while busy starts no frame and does not change the frame in flight.
- R9: `done` is a single-cycle pulse raised in the cycle in which `sync_n` returns high, once per frame.
- R10: After reset, `sync_n`=1, `sclk`=0, `din`=0, `cmd_ready`=1 and `done`=0.
- R11: The first rising `sclk` edge of a frame comes H system cycles after `sync_n` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_mode | input | 2 | Operating-mode field of the frame |
| cmd_code | input | 16 | Converter code of the frame |
| cfg_lsb_first | input | 1 | Byte engine shifts least-significant bit first |
| cfg_low_supply | input | 1 | Apply the slower serial-clock limit |
| sync_n | output | 1 | Active-low frame strobe |
| sclk | output | 1 | Serial clock, idle low |
| din | output | 1 | Serial data, valid at falling `sclk` |
| done | output | 1 | Frame-complete pulse |

## Verification
The bench builds the block with a 4 ns system clock and BYTE_IDLE=3. This gives half periods of 5 and 7 cycles and a 9-cycle sync gap, so every edge interval can be computed and checked exactly. All four mode values are swept with edge-case codes under all four combinations of bit order and supply range. A walking-one sweep over the code sends one frame per bit position, which exposes any swap or shift error in the mirrored path. Back-to-back commands put the sync gap at its minimum, and a command pulse injected mid-frame tests that a busy block ignores it.

// File: rtl/dacfm_pkg.sv
package dacfm_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_HIGH,
      ST_LOW,
      ST_PAUSE,
      ST_GAP
   } fm_state_t;

   function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
      return (num + den - 1) / den;
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/dacfm_mirror.sv
module dacfm_mirror #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] in_bits,
   output logic [W-1:0] out_bits
);

   if (W < 2) begin : g_bad_width
      $error("dacfm_mirror: W must be at least 2");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign out_bits[i] = in_bits[W-1-i];
   end

endmodule

// File: rtl/dacfm_byte_shifter.sv
module dacfm_byte_shifter #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         shift,
   input  logic         lsb_mode,
   input  logic [W-1:0] data,
   output logic         bit_out
);

   logic [W-1:0] sr_q;
   logic         mode_q;

   if (W < 2) begin : g_bad_width
      $error("dacfm_byte_shifter: W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q   <= '0;
         mode_q <= 1'b0;
      end else if (load) begin
         sr_q   <= data;
         mode_q <= lsb_mode;
      end else if (shift) begin
         if (mode_q) sr_q <= {1'b0, sr_q[W-1:1]};
         else        sr_q <= {sr_q[W-2:0], 1'b0};
      end
   end

   assign bit_out = mode_q ? sr_q[0] : sr_q[W-1];

   // R3
   load_shift_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(load && shift));

endmodule

// File: rtl/dac_frame_master.sv
module dac_frame_master
   import dacfm_pkg::*;
#(
   parameter int unsigned SYS_CLK_PS         = 4000,
   parameter int unsigned FAST_MIN_PERIOD_PS = 33334,
   parameter int unsigned SLOW_MIN_PERIOD_PS = 50000,
   parameter int unsigned SYNC_GAP_PS        = 33000,
   parameter int unsigned BYTE_IDLE          = 0,
   parameter int unsigned MODE_W             = 2,
   parameter int unsigned CODE_W             = 16,
   parameter int unsigned FRAME_W            = 24,
   parameter int unsigned BYTE_W             = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [MODE_W-1:0] cmd_mode,
   input  logic [CODE_W-1:0] cmd_code,
   input  logic              cfg_lsb_first,
   input  logic              cfg_low_supply,
   output logic              sync_n,
   output logic              sclk,
   output logic              din,
   output logic              done
);

   localparam int unsigned PAD_W     = FRAME_W - MODE_W - CODE_W;
   localparam int unsigned N_BYTES   = FRAME_W / BYTE_W;
   localparam int unsigned HALF_FAST = ceil_div(ceil_div(FAST_MIN_PERIOD_PS, 2), SYS_CLK_PS);
   localparam int unsigned HALF_SLOW = ceil_div(ceil_div(SLOW_MIN_PERIOD_PS, 2), SYS_CLK_PS);
   localparam int unsigned GAP_CYC   = ceil_div(SYNC_GAP_PS, SYS_CLK_PS);
   localparam int unsigned CNT_MAX   = max2(max2(HALF_FAST, HALF_SLOW), max2(GAP_CYC, BYTE_IDLE));
   localparam int unsigned CNT_W     = $clog2(CNT_MAX + 1);
   localparam int unsigned BIT_W     = $clog2(BYTE_W);
   localparam int unsigned BYTE_IW   = $clog2(N_BYTES);

   // elaboration-time parameter checks
   if (SYS_CLK_PS == 0) begin : g_bad_clk
      $error("dac_frame_master: SYS_CLK_PS must be non-zero");
   end
   if (FRAME_W % BYTE_W != 0) begin : g_bad_frame
      $error("dac_frame_master: FRAME_W must be a multiple of BYTE_W");
   end
   if (N_BYTES < 2) begin : g_bad_bytes
      $error("dac_frame_master: frame needs at least two bytes");
   end
   if (FRAME_W <= MODE_W + CODE_W) begin : g_bad_pad
      $error("dac_frame_master: frame must leave room for padding");
   end
   if (SLOW_MIN_PERIOD_PS < FAST_MIN_PERIOD_PS) begin : g_bad_rates
      $error("dac_frame_master: slow limit must not be faster than fast limit");
   end

   fm_state_t           state_q;
   logic [CNT_W-1:0]    cnt_q;
   logic [CNT_W-1:0]    half_q;
   logic [CNT_W-1:0]    lim;
   logic [CNT_W-1:0]    pause_lim;
   logic                has_pause;
   logic [BIT_W-1:0]    bit_q;
   logic [BYTE_IW-1:0]  byte_q;
   logic [FRAME_W-1:0]  frame_q;
   logic                lsb_q;
   logic [FRAME_W-1:0]  new_frame;
   logic [BYTE_W-1:0]   next_byte;
   logic [BYTE_W-1:0]   ld_byte;
   logic [BYTE_W-1:0]   ld_mirror;
   logic [BYTE_W-1:0]   ld_data;
   logic                ld_lsb;
   logic                accept;
   logic                cnt_done;
   logic                bit_last;
   logic                byte_last;
   logic                fall_now;
   logic                sh_load;
   logic                sh_shift;
   logic                sh_bit;

   // pause variant chosen by parameter
   if (BYTE_IDLE > 0) begin : g_pause
      assign has_pause = 1'b1;
      assign pause_lim = CNT_W'(BYTE_IDLE);
   end else begin : g_no_pause
      assign has_pause = 1'b0;
      assign pause_lim = CNT_W'(1);
   end

   assign cmd_ready = (state_q == ST_IDLE);
   assign accept    = cmd_valid && cmd_ready;
   assign new_frame = {{PAD_W{1'b0}}, cmd_mode, cmd_code};

   always_comb begin
      case (state_q)
         ST_PAUSE: lim = pause_lim;
         ST_GAP:   lim = CNT_W'(GAP_CYC);
         default:  lim = half_q;
      endcase
   end

   assign cnt_done  = (cnt_q == lim - CNT_W'(1));
   assign bit_last  = (bit_q == BIT_W'(BYTE_W - 1));
   assign byte_last = (byte_q == BYTE_IW'(N_BYTES - 1));
   assign fall_now  = (state_q == ST_HIGH) && cnt_done;

   // byte following the current one in the held frame
   always_comb begin
      next_byte = '0;
      for (int i = 0; i < N_BYTES; i++) begin
         if (BYTE_IW'(i) == byte_q + BYTE_IW'(1))
            next_byte = frame_q[FRAME_W-1-i*BYTE_W -: BYTE_W];
      end
   end

   assign ld_byte  = accept ? new_frame[FRAME_W-1 -: BYTE_W] : next_byte;
   assign ld_lsb   = accept ? cfg_lsb_first : lsb_q;
   assign ld_data  = ld_lsb ? ld_mirror : ld_byte;
   assign sh_load  = accept || (fall_now && bit_last && !byte_last);
   assign sh_shift = fall_now && !bit_last;

   dacfm_mirror #(.W(BYTE_W)) u_mirror (
      .in_bits  (ld_byte),
      .out_bits (ld_mirror)
   );

   dacfm_byte_shifter #(.W(BYTE_W)) u_shifter (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (sh_load),
      .shift    (sh_shift),
      .lsb_mode (ld_lsb),
      .data     (ld_data),
      .bit_out  (sh_bit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         half_q  <= CNT_W'(HALF_FAST);
         bit_q   <= '0;
         byte_q  <= '0;
         frame_q <= '0;
         lsb_q   <= 1'b0;
         sync_n  <= 1'b1;
         sclk    <= 1'b0;
         din     <= 1'b0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  state_q <= ST_SETUP;
                  cnt_q   <= '0;
                  bit_q   <= '0;
                  byte_q  <= '0;
                  frame_q <= new_frame;
                  lsb_q   <= cfg_lsb_first;
                  half_q  <= cfg_low_supply ? CNT_W'(HALF_SLOW) : CNT_W'(HALF_FAST);
                  sync_n  <= 1'b0;
               end
            end
            ST_SETUP, ST_PAUSE: begin
               if (cnt_done) begin
                  cnt_q   <= '0;
                  state_q <= ST_HIGH;
                  sclk    <= 1'b1;
                  din     <= sh_bit;
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            ST_HIGH: begin
               if (cnt_done) begin
                  cnt_q   <= '0;
                  state_q <= ST_LOW;
                  sclk    <= 1'b0;
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            ST_LOW: begin
               if (cnt_done) begin
                  cnt_q <= '0;
                  if (bit_last) begin
                     bit_q <= '0;
                     if (byte_last) begin
                        state_q <= ST_GAP;
                        sync_n  <= 1'b1;
                        din     <= 1'b0;
                        done    <= 1'b1;
                     end else begin
                        byte_q <= byte_q + BYTE_IW'(1);
                        if (has_pause) begin
                           state_q <= ST_PAUSE;
                        end else begin
                           state_q <= ST_HIGH;
                           sclk    <= 1'b1;
                           din     <= sh_bit;
                        end
                     end
                  end else begin
                     bit_q   <= bit_q + BIT_W'(1);
                     state_q <= ST_HIGH;
                     sclk    <= 1'b1;
                     din     <= sh_bit;
                  end
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            ST_GAP: begin
               if (cnt_done) begin
                  cnt_q   <= '0;
                  state_q <= ST_IDLE;
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // cycles the strobe has been high, saturating (assertion support)
   logic [CNT_W-1:0] hi_cnt_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           hi_cnt_q <= CNT_W'(GAP_CYC);
      else if (!sync_n)                     hi_cnt_q <= '0;
      else if (hi_cnt_q != CNT_W'(GAP_CYC)) hi_cnt_q <= hi_cnt_q + CNT_W'(1);
   end

   // R7
   sync_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sync_n) |-> (hi_cnt_q == CNT_W'(GAP_CYC)));

   // R8
   accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready) |=> !cmd_ready);

   // R8
   busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_n |-> !cmd_ready);

   // R9
   done_at_sync_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $rose(sync_n));

   // R9
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R5
   sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sync_n |-> !sclk);

   // R5
   din_stable_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sclk) |-> $stable(din));

   // R1
   fall_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sclk) |-> !sync_n);

endmodule

// File: tb/tb_dac_frame_master.sv
`timescale 1ns/1ps
module tb_dac_frame_master;

   localparam int CLK_PS   = 4000;
   localparam int IDLE_CYC = 3;
   localparam real TCLK    = 4.0;

   function automatic int cdiv(input int a, input int b);
      return (a + b - 1) / b;
   endfunction

   localparam int H_FAST  = cdiv(cdiv(33334, 2), CLK_PS);
   localparam int H_SLOW  = cdiv(cdiv(50000, 2), CLK_PS);
   localparam int GAP_EXP = cdiv(33000, CLK_PS);

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [1:0]  cmd_mode = '0;
   logic [15:0] cmd_code = '0;
   logic        cfg_lsb_first = 1'b0;
   logic        cfg_low_supply = 1'b0;
   logic        sync_n, sclk, din, done;

   always #2 clk = ~clk;

   dac_frame_master #(.SYS_CLK_PS(CLK_PS), .BYTE_IDLE(IDLE_CYC)) dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_mode(cmd_mode), .cmd_code(cmd_code), .cfg_lsb_first(cfg_lsb_first),
      .cfg_low_supply(cfg_low_supply), .sync_n(sync_n), .sclk(sclk), .din(din),
      .done(done));

   int  checks = 0;
   int  failures = 0;
   bit  finished = 0;
   int  cyc = 0;

   // monitor state
   int          h_cur = H_FAST;
   int          nfall = 0;
   int          falls_at_rise = 0;
   logic [23:0] cap = '0;
   realtime     t_last_fall = 0;
   realtime     t_sync_fall = 0;
   realtime     t_sync_rise = 0;
   bit          seen_rise = 0;
   int          interval_err = 0;
   int          setup_err = 0;
   int          tail_err = 0;
   int          gap_err = 0;
   int          gap_seen = 0;
   int          din_err = 0;
   int          idle_err = 0;
   int          ready_err = 0;
   int          done_cnt = 0;
   int          sync_falls = 0;
   logic        din_prev = 1'b0, sclk_prev = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic real absr(input real x);
      return (x < 0.0) ? -x : x;
   endfunction

   always @(negedge sync_n) begin
      if (rst_n) begin
         sync_falls++;
         if (seen_rise) begin
            gap_seen++;
            if ($realtime - t_sync_rise < GAP_EXP * TCLK - 0.01 ||
                $realtime - t_sync_rise < 33.0) gap_err++;
         end
         nfall = 0;
         cap = '0;
         t_sync_fall = $realtime;
      end
   end

   always @(posedge sync_n) begin
      if (rst_n) begin
         falls_at_rise = nfall;
         t_sync_rise = $realtime;
         seen_rise = 1;
         if (absr($realtime - t_last_fall - h_cur * TCLK) > 0.01) tail_err++;
      end
   end

   always @(posedge sclk) begin
      if (nfall == 0 && absr($realtime - t_sync_fall - h_cur * TCLK) > 0.01) setup_err++;
   end

   always @(negedge sclk) begin
      if (!sync_n) begin
         if (nfall > 0) begin
            if (absr($realtime - t_last_fall -
                     (2 * h_cur + ((nfall == 8 || nfall == 16) ? IDLE_CYC : 0)) * TCLK) > 0.01)
               interval_err++;
         end
         cap = {cap[22:0], din};
         nfall++;
         t_last_fall = $realtime;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (!sync_n && din != din_prev && !(sclk && !sclk_prev)) din_err++;
         if (sync_n && sclk) idle_err++;
         if (!sync_n && cmd_ready) ready_err++;
         if (done) begin
            done_cnt++;
            if (!sync_n) ready_err++;
         end
      end
      din_prev = din;
      sclk_prev = sclk;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !finished) begin
         finished = 1;
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic send_frame(input logic [1:0] mode, input logic [15:0] code,
                             input bit lsb, input bit low, input bit junk);
      logic [23:0] exp;
      int          d0;
      int          w;
      exp = {6'b000000, mode, code};
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      cfg_lsb_first  = lsb;
      cfg_low_supply = low;
      h_cur = low ? H_SLOW : H_FAST;
      cmd_mode = mode;
      cmd_code = code;
      cmd_valid = 1'b1;
      d0 = done_cnt;
      @(negedge clk);
      cmd_valid = 1'b0;
      if (junk) begin
         repeat (40) @(negedge clk);
         cmd_mode = ~mode;
         cmd_code = ~code;
         cmd_valid = 1'b1;
         @(negedge clk);
         cmd_valid = 1'b0;
      end
      w = 0;
      while (done_cnt == d0 && w < 2000) begin
         @(negedge clk);
         w++;
      end
      if (lsb) check(cap == exp, "R4", "mirrored wire word", cap, exp);
      else     check(cap == exp, "R3", "wire word", cap, exp);
      check(falls_at_rise == 24, "R1", "falls before sync rise", falls_at_rise, 24);
      check(interval_err == 0, "R2", "fall spacing errors", interval_err, 0);
      check(setup_err == 0 && tail_err == 0, "R11", "setup/tail errors",
            setup_err + tail_err, 0);
      check(din_err == 0 && idle_err == 0, "R5", "din/sclk phase errors",
            din_err + idle_err, 0);
      check(done_cnt == d0 + 1, "R9", "done pulses", done_cnt - d0, 1);
      check(ready_err == 0, "R8", "ready/done while busy", ready_err, 0);
   endtask

   initial begin
      logic [15:0] pats[4];
      int          f0;
      pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'hA5C3; pats[3] = 16'h5A3C;
      repeat (3) @(negedge clk);
      // R10 reset state
      check(sync_n == 1'b1, "R10", "sync_n in reset", sync_n, 1);
      check(sclk == 1'b0 && din == 1'b0, "R10", "sclk/din in reset", {sclk, din}, 0);
      check(cmd_ready == 1'b1 && done == 1'b0, "R10", "ready/done in reset",
            {cmd_ready, done}, 2);
      rst_n = 1'b1;
      @(negedge clk);
      check(sync_n == 1'b1 && cmd_ready == 1'b1, "R10", "idle after reset",
            {sync_n, cmd_ready}, 3);

      // R6 rate limits from the derived half periods
      check(H_FAST == 5 && H_SLOW == 7, "R6", "half periods", H_FAST * 16 + H_SLOW, 16'h57);
      check(2.0 * H_FAST * TCLK >= 1000.0 / 30.0, "R6", "fast period ps",
            2 * H_FAST * CLK_PS, 33334);
      check(2.0 * H_SLOW * TCLK >= 1000.0 / 20.0, "R6", "slow period ps",
            2 * H_SLOW * CLK_PS, 50000);

      // sweep: all modes x edge-case codes x bit order x supply range
      for (int cfg = 0; cfg < 4; cfg++) begin
         for (int m = 0; m < 4; m++) begin
            for (int p = 0; p < 4; p++) begin
               send_frame(2'(m), pats[p], cfg[0], cfg[1], 1'b0);
            end
         end
      end

      // walking one over the code in mirrored mode
      for (int b = 0; b < 16; b++) begin
         send_frame(2'(b % 4), 16'(1 << b), 1'b1, b[0], 1'b0);
      end

      // R8: command pulse while busy is ignored
      send_frame(2'b10, 16'h1234, 1'b0, 1'b0, 1'b1);
      f0 = sync_falls;
      repeat (60) @(negedge clk);
      check(sync_falls == f0 && sync_n == 1'b1, "R8", "frames after busy pulse",
            sync_falls - f0, 0);

      // R7 sync-high gap over all back-to-back frames
      check(gap_seen > 0 && gap_err == 0, "R7", "gap violations", gap_err, 0);
      check(t_sync_rise > 0, "R7", "frame end seen", seen_rise, 1);

      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule